// File: doc/BRIEF.md
# Two-Wire Bus Unwedge Sequencer

This block returns a two-wire serial bus to idle after a peripheral has been left mid-transfer and is holding the data line low. A single start request makes it take over the open-drain pull-down enables of both lines. It first lets both lines float. It then drives a fixed train of clock pulses, so that any peripheral still shifting out data can finish its byte and let go of SDA. On every pulse it watches SDA.

If SDA read high on any pulse, the block checks whether both lines now rest high. It then makes a START and a STOP while SCL stays released for the whole pair, and waits out the bus-free time. A peripheral that misbehaves when SCL drops between a START and a STOP therefore never sees that case. If SDA never read high, the block gives up and drives no SDA edge at all.

When the run ends, a one-cycle done pulse marks three results: the outcome, a warning that the lines were not at rest, and a separate error that a peripheral held SCL low past the stretch limit. All timings are set by parameters in microseconds, scaled by the number of clock cycles per microsecond.

Top module: `twowire_unwedge`

## Requirements
- R1: Out of reset and while idle, both pull-down enables are off, busy_o and done_o are low, and ok_o, not_rest_o and stretch_err_o read 0.
- R2: A start request first releases both lines for one phase time: the first SCL pull-down comes exactly PHASE+1 cycles after the cycle in which start_i is sampled high.
- R3: Exactly PULSES (default nine) clock pulses are generated. Each pulse is an SCL pull-down lasting exactly one phase time (PHASE cycles), followed by a release.
- R4: After each release, the block waits until SCL reads high (clock stretching). Only then does the high phase of at least PHASE cycles start, so SCL is never pulled low again before it has been high for PHASE cycles.
- R5: If SCL stays low for STRETCH cycles after a release, stretch_err_o is reported as 1 at done. The sequence still completes all pulses.
- R6: SDA is sampled once per pulse, when the high phase begins, and the samples are OR-ed together. Clocking continues for every pulse after a high has been seen, so a high on only the last pulse or only the first pulse counts.
- R7: If SDA never read high, done_o comes with ok_o = 0, and SDA is never pulled low during the run.
- R8: If SDA read high, one START and one STOP are made with SCL released throughout. SDA is pulled only while SCL is high, and the SCL pull-down never rises after the last pulse.
- R9: The SDA pull-down of the START/STOP pair lasts exactly HOLD cycles.
- R10: done_o rises exactly BUF cycles after SDA is released at the end of the STOP.
- R11: not_rest_o reports 1 when SDA had been seen high but either line read low just before the START. ok_o is still 1 in that case.
- R12: done_o is a one-cycle pulse. The result outputs change only with done_o and hold until the next run. A start request while a run is busy has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request a recovery run (taken only when idle) |
| scl_i | input | 1 | SCL line level as read from the pad |
| sda_i | input | 1 | SDA line level as read from the pad |
| scl_pd_o | output | 1 | SCL open-drain pull-down enable |
| sda_pd_o | output | 1 | SDA open-drain pull-down enable |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle end-of-run pulse |
| ok_o | output | 1 | SDA was seen high and START/STOP was issued |
| not_rest_o | output | 1 | Lines were not both high before the START |
| stretch_err_o | output | 1 | SCL stretch limit exceeded on some pulse |

## Verification
The hardest cases to reach are SDA states that change from pulse to pulse: a peripheral that releases SDA only on the ninth pulse, and one that releases it only on the first pulse and grabs it again afterwards. The bench models a peripheral on open-drain lines. It counts SCL falling edges and applies a per-pulse SDA mask, so each pattern is driven exactly onto the pulse it names. The same model can hold SCL low for a set time after each release, or hold it low forever, which exercises both the stretch wait and the stretch timeout.

// File: rtl/uw_pkg.sv
package uw_pkg;
  typedef enum logic [3:0] {
    S_IDLE, S_REL, S_LOW, S_RISE, S_HIGH, S_CHECK, S_SETUP, S_HOLD, S_BUF, S_DONE
  } uw_state_e;

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/uw_sync.sv
module uw_sync #(
  parameter int unsigned W      = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  generate
    if (STAGES == 0) begin : g_bypass
      assign q_o = d_i;
    end else begin : g_chain
      logic [W-1:0] pipe_q [STAGES];
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          for (int i = 0; i < STAGES; i++) pipe_q[i] <= '1;  // idle bus reads high
        end else begin
          pipe_q[0] <= d_i;
          for (int i = 1; i < STAGES; i++) pipe_q[i] <= pipe_q[i-1];
        end
      end
      assign q_o = pipe_q[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/uw_timer.sv
module uw_timer #(
  parameter int unsigned TW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [TW-1:0] val_i,
  output logic          zero_o
);
  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (load_i)        cnt_q <= val_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);

  // R3: an expired timer stays expired until reloaded
  a_r3_tmr_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (zero_o && !load_i) |=> zero_o);
endmodule

// File: rtl/uw_fsm.sv
module uw_fsm
  import uw_pkg::*;
#(
  parameter int unsigned PULSES    = 9,
  parameter int unsigned PHASE_C   = 100,
  parameter int unsigned SETUP_C   = 50,
  parameter int unsigned HOLD_C    = 50,
  parameter int unsigned BUF_C     = 3000,
  parameter int unsigned STRETCH_C = 50000,
  parameter int unsigned TW        = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          scl_s_i,
  input  logic          sda_s_i,
  input  logic          tmr_zero_i,
  output logic          tmr_load_o,
  output logic [TW-1:0] tmr_val_o,
  output logic          scl_pd_o,
  output logic          sda_pd_o,
  output logic          busy_o,
  output logic          done_o,
  output logic          ok_o,
  output logic          not_rest_o,
  output logic          stretch_err_o
);
  localparam int unsigned CW = $clog2(PULSES + 1);
  localparam logic [TW-1:0] PHASE_V   = TW'(PHASE_C - 1);
  localparam logic [TW-1:0] SETUP_V   = TW'(SETUP_C - 1);
  localparam logic [TW-1:0] HOLD_V    = TW'(HOLD_C - 1);
  localparam logic [TW-1:0] BUF_V     = TW'(BUF_C - 1);
  localparam logic [TW-1:0] STRETCH_V = TW'(STRETCH_C - 1);
  localparam logic [CW-1:0] LAST_P    = CW'(PULSES - 1);

  uw_state_e     state_q, state_d;
  logic [CW-1:0] pulse_q;
  logic          seen_q, tmo_q, nr_q, used_q;
  logic          ok_q, nrest_q, serr_q;

  always_comb begin
    state_d    = state_q;
    tmr_load_o = 1'b0;
    tmr_val_o  = '0;
    unique case (state_q)
      S_IDLE: if (start_i) begin
        state_d = S_REL; tmr_load_o = 1'b1; tmr_val_o = PHASE_V;
      end
      S_REL: if (tmr_zero_i) begin
        state_d = S_LOW; tmr_load_o = 1'b1; tmr_val_o = PHASE_V;
      end
      S_LOW: if (tmr_zero_i) begin
        state_d = S_RISE; tmr_load_o = 1'b1; tmr_val_o = STRETCH_V;
      end
      S_RISE: if (scl_s_i || tmr_zero_i) begin
        state_d = S_HIGH; tmr_load_o = 1'b1; tmr_val_o = PHASE_V;
      end
      S_HIGH: if (tmr_zero_i) begin
        if (pulse_q == LAST_P) state_d = S_CHECK;
        else begin
          state_d = S_LOW; tmr_load_o = 1'b1; tmr_val_o = PHASE_V;
        end
      end
      S_CHECK: if (seen_q) begin
        state_d = S_SETUP; tmr_load_o = 1'b1; tmr_val_o = SETUP_V;
      end else state_d = S_DONE;
      S_SETUP: if (tmr_zero_i) begin
        state_d = S_HOLD; tmr_load_o = 1'b1; tmr_val_o = HOLD_V;
      end
      S_HOLD: if (tmr_zero_i) begin
        state_d = S_BUF; tmr_load_o = 1'b1; tmr_val_o = BUF_V;
      end
      S_BUF:  if (tmr_zero_i) state_d = S_DONE;
      S_DONE: state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      pulse_q <= '0;
      seen_q  <= 1'b0;
      tmo_q   <= 1'b0;
      nr_q    <= 1'b0;
      used_q  <= 1'b0;
      ok_q    <= 1'b0;
      nrest_q <= 1'b0;
      serr_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      if (state_q == S_IDLE && start_i) begin
        pulse_q <= '0;
        seen_q  <= 1'b0;
        tmo_q   <= 1'b0;
        nr_q    <= 1'b0;
        used_q  <= 1'b0;
      end
      if (state_q == S_RISE && state_d == S_HIGH) begin
        seen_q <= seen_q | sda_s_i;
        if (!scl_s_i) tmo_q <= 1'b1;  // left on timeout, not on rise
      end
      if (state_q == S_HIGH && state_d != S_HIGH) pulse_q <= pulse_q + 1'b1;
      if (state_q == S_CHECK) nr_q <= seen_q & ~(scl_s_i & sda_s_i);
      if (sda_pd_o) used_q <= 1'b1;
      if (state_d == S_DONE && state_q != S_DONE) begin
        ok_q    <= seen_q;
        nrest_q <= seen_q & nr_q;
        serr_q  <= tmo_q;
      end
    end
  end

  assign scl_pd_o      = (state_q == S_LOW);
  assign sda_pd_o      = (state_q == S_HOLD);
  assign busy_o        = (state_q != S_IDLE);
  assign done_o        = (state_q == S_DONE);
  assign ok_o          = ok_q;
  assign not_rest_o    = nrest_q;
  assign stretch_err_o = serr_q;

  // R8: SDA is never pulled while SCL is pulled
  a_r8_no_dual_pull: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sda_pd_o |-> !scl_pd_o);
  // R12: done lasts one cycle
  a_r12_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R12: results move only together with done
  a_r12_result_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$stable(ok_o) || !$stable(not_rest_o) || !$stable(stretch_err_o)) |-> done_o);
  // R7: a failed run never touched SDA
  a_r7_fail_no_pull: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !ok_o) |-> !used_q);
  // R4: high phase begins only on a seen rise or on timeout
  a_r4_rise_wait: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_HIGH && $past(state_q) == S_RISE) |-> ($past(scl_s_i) || $past(tmr_zero_i)));
  // R1: idle leaves both lines free
  a_r1_idle_free: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (!scl_pd_o && !sda_pd_o));
endmodule

// File: rtl/twowire_unwedge.sv
module twowire_unwedge
  import uw_pkg::*;
#(
  parameter int unsigned CYC_PER_US  = 50,
  parameter int unsigned PULSES      = 9,
  parameter int unsigned PHASE_US    = 2,
  parameter int unsigned SETUP_US    = 1,
  parameter int unsigned HOLD_US     = 1,
  parameter int unsigned BUF_US      = 60,
  parameter int unsigned STRETCH_US  = 1000,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_pd_o,
  output logic sda_pd_o,
  output logic busy_o,
  output logic done_o,
  output logic ok_o,
  output logic not_rest_o,
  output logic stretch_err_o
);
  localparam int unsigned PHASE_C   = CYC_PER_US * PHASE_US;
  localparam int unsigned SETUP_C   = CYC_PER_US * SETUP_US;
  localparam int unsigned HOLD_C    = CYC_PER_US * HOLD_US;
  localparam int unsigned BUF_C     = CYC_PER_US * BUF_US;
  localparam int unsigned STRETCH_C = CYC_PER_US * STRETCH_US;
  localparam int unsigned MAX_C     = max2(max2(max2(PHASE_C, SETUP_C), max2(HOLD_C, BUF_C)), STRETCH_C);
  localparam int unsigned TW        = $clog2(MAX_C + 1);

  logic [1:0]    lines_s;
  logic          tmr_load, tmr_zero;
  logic [TW-1:0] tmr_val;

  uw_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({scl_i, sda_i}),
    .q_o   (lines_s)
  );

  uw_timer #(.TW(TW)) u_timer (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(tmr_load),
    .val_i (tmr_val),
    .zero_o(tmr_zero)
  );

  uw_fsm #(
    .PULSES(PULSES), .PHASE_C(PHASE_C), .SETUP_C(SETUP_C), .HOLD_C(HOLD_C),
    .BUF_C(BUF_C), .STRETCH_C(STRETCH_C), .TW(TW)
  ) u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (start_i),
    .scl_s_i      (lines_s[1]),
    .sda_s_i      (lines_s[0]),
    .tmr_zero_i   (tmr_zero),
    .tmr_load_o   (tmr_load),
    .tmr_val_o    (tmr_val),
    .scl_pd_o     (scl_pd_o),
    .sda_pd_o     (sda_pd_o),
    .busy_o       (busy_o),
    .done_o       (done_o),
    .ok_o         (ok_o),
    .not_rest_o   (not_rest_o),
    .stretch_err_o(stretch_err_o)
  );
endmodule

// File: tb/sim_twowire_unwedge.sv
module sim_twowire_unwedge;
  localparam int CPU   = 4;
  localparam int PHASE = CPU * 2;
  localparam int HOLD  = CPU * 1;
  localparam int BUFC  = CPU * 15;
  localparam int STR   = CPU * 25;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic scl_pd, sda_pd, busy, done, ok, nrest, serr;
  logic scl_line, sda_line;

  // peripheral model
  logic [8:0] mask = '0;
  logic       scl_stuck = 1'b0;
  int         stretch_n = 0;
  int         hold_cnt = 0;
  int         pidx = 0;

  int n_chk = 0, n_fail = 0, cyc = 0;

  always #10 clk = ~clk;

  assign scl_line = !scl_pd && (hold_cnt == 0) && !scl_stuck;
  assign sda_line = !sda_pd && !((pidx >= 1) && mask[pidx-1]);

  twowire_unwedge #(
    .CYC_PER_US(CPU), .PHASE_US(2), .SETUP_US(1), .HOLD_US(1),
    .BUF_US(15), .STRETCH_US(25)
  ) u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .scl_i(scl_line), .sda_i(sda_line),
    .scl_pd_o(scl_pd), .sda_pd_o(sda_pd), .busy_o(busy), .done_o(done),
    .ok_o(ok), .not_rest_o(nrest), .stretch_err_o(serr)
  );

  always @(posedge clk) begin
    if (scl_pd) hold_cnt <= stretch_n;
    else if (hold_cnt != 0) hold_cnt <= hold_cnt - 1;
  end

  // monitor, sampled at negedge
  int  pd_rises, low_run, low_min, low_max, hi_run, hi_min, sda_run, sda_len;
  int  gap, gap_done, s2p, s2p_rec, both_pd, bad_start, bad_stop, sda_cnt;
  int  done_cnt, done_run, done_max, idle_pd, post_pd;
  logic prev_scl_pd = 1'b0, prev_sda_pd = 1'b0, prev_scl = 1'b1, gap_on = 1'b0;
  logic r_ok, r_nr, r_se;

  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (start && !busy) begin
      pd_rises = 0; low_min = 1 << 20; low_max = 0; hi_min = 1 << 20; sda_len = 0;
      gap_done = -1; s2p = 0; s2p_rec = -1; both_pd = 0; bad_start = 0; bad_stop = 0;
      sda_cnt = 0; done_cnt = 0; done_max = 0; post_pd = 0; pidx = 0; gap_on = 1'b0;
    end else begin
      s2p = s2p + 1;
    end
    if (scl_pd && !prev_scl_pd) begin
      pd_rises++;
      if (s2p_rec < 0) s2p_rec = s2p;
      if (hi_run < hi_min) hi_min = hi_run;
      if (pd_rises > 9) post_pd++;
    end
    if (scl_pd) low_run++;
    else if (prev_scl_pd) begin
      if (low_run < low_min) low_min = low_run;
      if (low_run > low_max) low_max = low_run;
      low_run = 0;
    end
    if (scl_line) hi_run++; else hi_run = 0;
    if (prev_scl && !scl_line && pidx < 9) pidx = pidx + 1;
    if (scl_pd && sda_pd) both_pd++;
    if (!busy && (scl_pd || sda_pd)) idle_pd++;
    if (sda_pd && !prev_sda_pd) begin sda_cnt++; if (!scl_line) bad_start++; end
    if (sda_pd) sda_run++;
    if (!sda_pd && prev_sda_pd) begin
      sda_len = sda_run; sda_run = 0; gap = 0; gap_on = 1'b1;
      if (!scl_line) bad_stop++;
    end else if (gap_on) gap++;
    if (done) begin
      done_cnt++; done_run++;
      if (gap_on) begin gap_done = gap; gap_on = 1'b0; end
      r_ok = ok; r_nr = nrest; r_se = serr;
    end else done_run = 0;
    if (done_run > done_max) done_max = done_run;
    prev_scl_pd = scl_pd; prev_sda_pd = sda_pd; prev_scl = scl_line;
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic run(input logic [8:0] m, input logic stuck, input int sn, input logic extra_start);
    bit got;
    mask = m; scl_stuck = stuck; stretch_n = sn;
    @(posedge clk); #1 start = 1'b1;
    @(posedge clk); #1 start = 1'b0;
    if (extra_start) begin
      repeat (40) @(posedge clk);
      #1 start = 1'b1; @(posedge clk); #1 start = 1'b0;
    end
    got = 0;
    for (int i = 0; i < 5000 && !got; i++) begin
      @(negedge clk);
      if (done) got = 1;
    end
    chk("R12 done seen", int'(got), 1);
    repeat (5) @(negedge clk);
    mask = '0; scl_stuck = 1'b0; stretch_n = 0;
    repeat (5) @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1 scl_pd", int'(scl_pd), 0);
    chk("R1 sda_pd", int'(sda_pd), 0);
    chk("R1 busy", int'(busy), 0);
    chk("R1 done", int'(done), 0);
    chk("R1 results", int'({ok, nrest, serr}), 0);
  endtask

  task automatic t_clean();
    run(9'h000, 1'b0, 0, 1'b0);
    chk("R2 first pull delay", s2p_rec, PHASE + 1);
    chk("R3 pulse count", pd_rises, 9);
    chk("R3 low min", low_min, PHASE);
    chk("R3 low max", low_max, PHASE);
    chk("R8 start under scl high", bad_start, 0);
    chk("R8 stop under scl high", bad_stop, 0);
    chk("R8 one sda pull", sda_cnt, 1);
    chk("R8 no dual pull", both_pd, 0);
    chk("R9 hold length", sda_len, HOLD);
    chk("R10 bus free", gap_done, BUFC);
    chk("R12 done width", done_max, 1);
    chk("R7 ok clean", int'(r_ok), 1);
    chk("R11 rest clean", int'(r_nr), 0);
    chk("R5 no stretch err", int'(r_se), 0);
    chk("R12 result held", int'(ok), 1);
  endtask

  task automatic t_wedged();
    run(9'h1FF, 1'b0, 0, 1'b0);
    chk("R7 fail ok", int'(r_ok), 0);
    chk("R7 no sda pull", sda_cnt, 0);
    chk("R3 pulses on fail", pd_rises, 9);
    chk("R11 no warn on fail", int'(r_nr), 0);
  endtask

  task automatic t_last_only();
    run(9'h0FF, 1'b0, 0, 1'b0);
    chk("R6 high on last pulse", int'(r_ok), 1);
    chk("R11 rest after last", int'(r_nr), 0);
  endtask

  task automatic t_first_only();
    run(9'h1FE, 1'b0, 0, 1'b0);
    chk("R6 high on first pulse", int'(r_ok), 1);
    chk("R6 clocking continues", pd_rises, 9);
    chk("R11 not at rest", int'(r_nr), 1);
  endtask

  task automatic t_stretch();
    run(9'h000, 1'b0, 20, 1'b0);
    chk("R4 pulse count", pd_rises, 9);
    chk("R4 high phase kept", int'(hi_min >= PHASE), 1);
    chk("R4 no stretch err", int'(r_se), 0);
    chk("R4 ok", int'(r_ok), 1);
  endtask

  task automatic t_stuck();
    run(9'h000, 1'b1, 0, 1'b0);
    chk("R5 stretch err", int'(r_se), 1);
    chk("R5 pulses continue", pd_rises, 9);
    chk("R11 scl low warn", int'(r_nr), 1);
  endtask

  task automatic t_busy_start();
    run(9'h000, 1'b0, 0, 1'b1);
    chk("R12 busy start pulses", pd_rises, 9);
    chk("R12 single done", done_cnt, 1);
    chk("R8 no scl pull after pulses", post_pd, 0);
    chk("R1 idle pulls", idle_pd, 0);
  endtask

  initial begin
    idle_pd = 0; sda_run = 0; low_run = 0; hi_run = 0; gap = 0; done_run = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_clean();
    t_wedged();
    t_last_only();
    t_first_only();
    t_stretch();
    t_stuck();
    t_busy_start();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    wait (cyc > 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule